// File: doc/BRIEF.md
# String Operation Sequencer

This block carries out a single pass of a memory string operation: copy an element from the source index to the destination index, compare the elements at the two indices, compare the accumulator with the element at the destination index, fetch an element into the accumulator, or write the accumulator out to memory. The block keeps the source index, the destination index and the accumulator as its own registers. These can be preset through a load port while the block is idle. An operation is selected by an operation code, an element size, an address width mode and a direction bit. It is launched with a one-cycle `start` pulse.

The block makes one memory access at a time on a simple request/acknowledge port. A response can be a normal acknowledge or an abort. An abort ends the operation at once, and all architectural state is left as it was. When the operation finishes, `done` pulses for one cycle. In that cycle the block also reports whether the operation was aborted and the fixed cycle cost of the operation class. Compare operations produce zero, sign, borrow and overflow flags from a subtraction at the element width.

Top module: `strop_seq`

## Requirements
- R1: On a completed operation, each index that the operation uses changes by the element size (esize 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The index is incremented when `dir` is 0 and decremented when `dir` is 1.
- R2: When `addr32` is 0, memory addresses are the low 16 bits of the index, zero-extended. Only those low 16 bits step, wrapping modulo 65536, and bits 31:16 are kept. When `addr32` is 1, the full 32-bit index is used and steps with 32-bit wrap.
- R3: A copy operation (op 0) first reads at the source address, then writes the same element at the destination address with `mem_we` = 1. After that, both indices step.
- R4: If any access is answered with `mem_abort`, the operation ends with `aborted` = 1. No further access is made, and the indices, accumulator, flags and memory are left unchanged.
- R5: Compare-strings (op 1) reads the source element and then the destination element, sets the flags from source minus destination, and steps both indices. Scan (op 2) reads only at the destination, sets the flags from accumulator slice minus element, and steps only the destination index.
- R6: The flags come from a subtraction at the element width. `zf` is set when the result is zero, `sf` is the result's top bit, `cf` is the unsigned borrow and `of` is signed overflow. Operations other than compare and scan, and aborted ones, leave the flags unchanged.
- R7: Load (op 3) reads at the source address and replaces only the low 1, 2 or 4 bytes of the accumulator. It steps only the source index.
- R8: Store (op 4) writes the low element-size bytes of the accumulator at the destination address and steps only the destination index. The source index and accumulator are unchanged.
- R9: `cost` is valid while `done` is high: 7 for copy, 4 for store, 5 for load, 7 for scan, and for compare 8 with `newgen` = 1 or 10 with `newgen` = 0.
- R10: `mem_req` stays high with a stable address and write enable until `mem_ack` or `mem_abort` is seen. At most one access is in flight. `done` is a single-cycle pulse, and `mem_req` is low whenever `busy` is low.
- R11: Operation codes 5 to 7 complete with `done`, make no memory access, report `cost` 0 and change no state.
- R12: After a synchronous active-low reset, the indices, accumulator and flags are zero, and `busy`, `done` and `mem_req` are low. While the block is idle, `ld_en` loads `ld_si`, `ld_di` and `ld_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (sampled when idle) |
| op | input | 3 | Operation: 0 copy, 1 compare-strings, 2 scan, 3 load, 4 store |
| esize | input | 2 | Element size: 0 byte, 1 two bytes, 2 or 3 four bytes |
| addr32 | input | 1 | 1 = 32-bit indices, 0 = 16-bit indices |
| dir | input | 1 | 0 = step up, 1 = step down |
| newgen | input | 1 | Selects the faster compare cost |
| ld_en | input | 1 | Preset registers when idle |
| ld_si | input | 32 | Source index preset value |
| ld_di | input | 32 | Destination index preset value |
| ld_acc | input | 32 | Accumulator preset value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Access address |
| mem_size | output | 2 | Access size, same code as esize |
| mem_wdata | output | 32 | Write data, zero above the element |
| mem_ack | input | 1 | Access completed |
| mem_abort | input | 1 | Access faulted |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Operation ended by abort (valid with done) |
| cost | output | 4 | Cycle cost of the operation (valid with done) |
| si | output | 32 | Source index register |
| di | output | 32 | Destination index register |
| acc | output | 32 | Accumulator register |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| cf | output | 1 | Borrow flag |
| of | output | 1 | Signed overflow flag |

## Verification
The bench targets these failure modes:
- 16-bit index wrap in both directions, with distinctive upper bits. A design that carried into bit 16 or cleared the upper half would show a wrong index at once.
- Compare and scan with operands whose borrow and sign flip when the operands are swapped, so a reversed operand order gives wrong `cf`/`sf`. A signed overflow case at each end catches an overflow taken from the wrong bit.
- Aborts injected on the first read, on the second read, and on the copy's write. A design that stepped an index or let a write through would show changed registers or changed memory bytes.
- Byte and word loads over a full accumulator, which expose a design that clears the bytes it should keep.

// File: rtl/strop_pkg.sv
// Shared constants, types and helpers for the string operation sequencer.
// Assumes a 32-bit data path; element sizes of 1, 2 and 4 bytes.
package strop_pkg;

    localparam int DW = 32;

    // operation codes seen on the op input
    localparam logic [2:0] OP_MOVE  = 3'd0;
    localparam logic [2:0] OP_CMP   = 3'd1;
    localparam logic [2:0] OP_SCAN  = 3'd2;
    localparam logic [2:0] OP_LOAD  = 3'd3;
    localparam logic [2:0] OP_STORE = 3'd4;

    // fixed cycle cost per operation class
    localparam logic [3:0] COST_MOVE    = 4'd7;
    localparam logic [3:0] COST_STORE   = 4'd4;
    localparam logic [3:0] COST_LOAD    = 4'd5;
    localparam logic [3:0] COST_SCAN    = 4'd7;
    localparam logic [3:0] COST_CMP_NEW = 4'd8;
    localparam logic [3:0] COST_CMP_OLD = 4'd10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RSRC,
        ST_RDST,
        ST_WDST,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic cf;
        logic of;
    } flags_t;

    // byte count of an element size code
    function automatic logic [2:0] elem_bytes(input logic [1:0] esz);
        case (esz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // bit mask covering one element
    function automatic logic [DW-1:0] elem_mask(input logic [1:0] esz);
        case (esz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // first access state an operation enters after start
    function automatic st_e first_state(input logic [2:0] opc);
        case (opc)
            OP_MOVE, OP_CMP, OP_LOAD: return ST_RSRC;
            OP_SCAN:                  return ST_RDST;
            OP_STORE:                 return ST_WDST;
            default:                  return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/strop_step.sv
// Index stepper: forms the effective address of an index register and its
// post-operation value. Assumes the short mode keeps the upper bits intact
// and wraps only the low SHORT bits.
module strop_step
    import strop_pkg::*;
#(
    parameter int XLEN  = DW,
    parameter int SHORT = 16
) (
    input  logic [XLEN-1:0] cur,
    input  logic [1:0]      esize,
    input  logic            dir,
    input  logic            wide,
    output logic [XLEN-1:0] ea,
    output logic [XLEN-1:0] nxt
);

    localparam int HI = XLEN - SHORT;

    logic [XLEN-1:0]  step;
    logic [XLEN-1:0]  full;
    logic [SHORT-1:0] low;

    // compute step, wrapped short value and effective address
    always_comb begin
        step = XLEN'(elem_bytes(esize));
        full = dir ? cur - step : cur + step;
        low  = dir ? cur[SHORT-1:0] - step[SHORT-1:0]
                   : cur[SHORT-1:0] + step[SHORT-1:0];
        nxt  = wide ? full : {cur[XLEN-1:SHORT], low};
        ea   = wide ? cur  : {{HI{1'b0}}, cur[SHORT-1:0]};
    end

endmodule

// File: rtl/strop_subflags.sv
// Subtract-style flag unit: evaluates lhs - rhs at each element width in
// parallel and selects by element size. Assumes operands are aligned to bit 0.
module strop_subflags
    import strop_pkg::*;
#(
    parameter int XLEN = DW
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [1:0]      esize,
    output flags_t          flg
);

    localparam int NW = 3;

    flags_t cand [NW];

    for (genvar g = 0; g < NW; g++) begin : g_wid
        localparam int W = 8 << g;
        logic [W:0] diff;
        // borrow-extended difference at width W
        assign diff    = {1'b0, lhs[W-1:0]} - {1'b0, rhs[W-1:0]};
        assign cand[g] = '{zf: (diff[W-1:0] == '0),
                           sf: diff[W-1],
                           cf: diff[W],
                           of: (lhs[W-1] ^ rhs[W-1]) & (diff[W-1] ^ lhs[W-1])};
    end

    // pick the candidate for the active element size
    always_comb begin
        case (esize)
            2'd0:    flg = cand[0];
            2'd1:    flg = cand[1];
            default: flg = cand[2];
        endcase
    end

endmodule

// File: rtl/strop_cost.sv
// Cost table: fixed cycle cost per operation class, with a generation
// option for compare-strings. Assumes reserved codes cost nothing.
module strop_cost
    import strop_pkg::*;
(
    input  logic [2:0] op,
    input  logic       newgen,
    output logic [3:0] cost
);

    // map operation class to its cost
    always_comb begin
        case (op)
            OP_MOVE:  cost = COST_MOVE;
            OP_CMP:   cost = newgen ? COST_CMP_NEW : COST_CMP_OLD;
            OP_SCAN:  cost = COST_SCAN;
            OP_LOAD:  cost = COST_LOAD;
            OP_STORE: cost = COST_STORE;
            default:  cost = 4'd0;
        endcase
    end

endmodule

// File: rtl/strop_seq.sv
// String operation sequencer: runs one copy, compare, scan, load or store
// pass over the index registers and accumulator, one memory access at a time.
// Assumes the memory port answers each request with ack or abort, abort
// taking priority; all state commits only on the final successful response.
module strop_seq
    import strop_pkg::*;
#(
    parameter int XLEN = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic [1:0]      esize,
    input  logic            addr32,
    input  logic            dir,
    input  logic            newgen,
    input  logic            ld_en,
    input  logic [XLEN-1:0] ld_si,
    input  logic [XLEN-1:0] ld_di,
    input  logic [XLEN-1:0] ld_acc,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [1:0]      mem_size,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic            mem_abort,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            aborted,
    output logic [3:0]      cost,
    output logic [XLEN-1:0] si,
    output logic [XLEN-1:0] di,
    output logic [XLEN-1:0] acc,
    output logic            zf,
    output logic            sf,
    output logic            cf,
    output logic            of
);

    localparam int NB = XLEN / 8;

    st_e             st;
    logic [2:0]      op_q;
    logic [1:0]      esz_q;
    logic            a32_q;
    logic            dir_q;
    logic            ng_q;
    logic            ab_q;
    logic [XLEN-1:0] tmp_q;
    flags_t          flg_q;

    logic [XLEN-1:0] si_ea, si_nxt, di_ea, di_nxt;
    logic [XLEN-1:0] acc_ld;
    logic [XLEN-1:0] emask;
    flags_t          flg_new;
    logic            rsp;

    strop_step #(.XLEN(XLEN)) u_src_step (
        .cur   (si),
        .esize (esz_q),
        .dir   (dir_q),
        .wide  (a32_q),
        .ea    (si_ea),
        .nxt   (si_nxt)
    );

    strop_step #(.XLEN(XLEN)) u_dst_step (
        .cur   (di),
        .esize (esz_q),
        .dir   (dir_q),
        .wide  (a32_q),
        .ea    (di_ea),
        .nxt   (di_nxt)
    );

    strop_subflags #(.XLEN(XLEN)) u_flags (
        .lhs   ((op_q == OP_CMP) ? tmp_q : acc),
        .rhs   (mem_rdata & emask),
        .esize (esz_q),
        .flg   (flg_new)
    );

    strop_cost u_cost (
        .op     (op_q),
        .newgen (ng_q),
        .cost   (cost)
    );

    assign emask = elem_mask(esz_q);
    assign rsp   = mem_ack | mem_abort;

    // accumulator merge: replace only the lanes the element covers
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign acc_ld[8*g +: 8] = (g < int'(elem_bytes(esz_q))) ? mem_rdata[8*g +: 8]
                                                                : acc[8*g +: 8];
    end

    // memory port drive from the current access state
    always_comb begin
        mem_req   = (st == ST_RSRC) || (st == ST_RDST) || (st == ST_WDST);
        mem_we    = (st == ST_WDST);
        mem_addr  = (st == ST_RSRC) ? si_ea : di_ea;
        mem_size  = esz_q;
        mem_wdata = ((op_q == OP_MOVE) ? tmp_q : acc) & emask;
    end

    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_DONE);
    assign aborted = ab_q;
    assign zf      = flg_q.zf;
    assign sf      = flg_q.sf;
    assign cf      = flg_q.cf;
    assign of      = flg_q.of;

    // sequencer state and architectural register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            op_q  <= '0;
            esz_q <= '0;
            a32_q <= 1'b0;
            dir_q <= 1'b0;
            ng_q  <= 1'b0;
            ab_q  <= 1'b0;
            tmp_q <= '0;
            flg_q <= '0;
            si    <= '0;
            di    <= '0;
            acc   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (ld_en) begin
                        si  <= ld_si;
                        di  <= ld_di;
                        acc <= ld_acc;
                    end
                    if (start) begin
                        op_q  <= op;
                        esz_q <= esize;
                        a32_q <= addr32;
                        dir_q <= dir;
                        ng_q  <= newgen;
                        ab_q  <= 1'b0;
                        st    <= first_state(op);
                    end
                end
                ST_RSRC: begin
                    if (rsp) begin
                        if (mem_abort) begin
                            ab_q <= 1'b1;
                            st   <= ST_DONE;
                        end else begin
                            tmp_q <= mem_rdata & emask;
                            case (op_q)
                                OP_MOVE: st <= ST_WDST;
                                OP_CMP:  st <= ST_RDST;
                                default: begin
                                    acc <= acc_ld;
                                    si  <= si_nxt;
                                    st  <= ST_DONE;
                                end
                            endcase
                        end
                    end
                end
                ST_RDST: begin
                    if (rsp) begin
                        if (mem_abort) begin
                            ab_q <= 1'b1;
                        end else begin
                            flg_q <= flg_new;
                            di    <= di_nxt;
                            if (op_q == OP_CMP) si <= si_nxt;
                        end
                        st <= ST_DONE;
                    end
                end
                ST_WDST: begin
                    if (rsp) begin
                        if (mem_abort) begin
                            ab_q <= 1'b1;
                        end else begin
                            di <= di_nxt;
                            if (op_q == OP_MOVE) si <= si_nxt;
                        end
                        st <= ST_DONE;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // request is held steady until the port answers
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    // completion is a single-cycle pulse
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    // no request while idle
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10

    // an aborted pass leaves the registers alone
    AST_ABORT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && aborted) |-> ($stable(si) && $stable(di) && $stable(acc))); // R4

    // load never touches the destination index
    AST_LOAD_KEEPS_DI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !aborted && op_q == OP_LOAD) |-> $stable(di)); // R7

    // store never touches the source index or accumulator
    AST_STORE_KEEPS_SI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !aborted && op_q == OP_STORE) |-> ($stable(si) && $stable(acc))); // R8

    // only copy and store may write memory
    AST_WRITE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (op_q == OP_MOVE || op_q == OP_STORE)); // R3

    // reserved codes never reach the memory port
    AST_RSV_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q > OP_STORE) |-> !mem_req); // R11

endmodule

// File: tb/strop_seq_tb_top.sv
// Scoreboard bench: the driver predicts each pass and queues the result,
// a monitor pops and compares on every done pulse.
module strop_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  esize = '0;
    logic        addr32 = 1'b0;
    logic        dir = 1'b0;
    logic        newgen = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_si = '0, ld_di = '0, ld_acc = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0, mem_abort = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, aborted;
    logic [3:0]  cost;
    logic [31:0] si, di, acc;
    logic        zf, sf, cf, of;

    strop_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .esize(esize),
        .addr32(addr32), .dir(dir), .newgen(newgen), .ld_en(ld_en),
        .ld_si(ld_si), .ld_di(ld_di), .ld_acc(ld_acc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_abort(mem_abort), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .aborted(aborted), .cost(cost),
        .si(si), .di(di), .acc(acc), .zf(zf), .sf(sf), .cf(cf), .of(of)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0]  mem [256];
    logic        fault_en = 1'b0;
    logic [31:0] fault_addr = '0;
    logic [31:0] log_a [$];
    bit          log_w [$];

    typedef struct {
        logic [31:0] si, di, acc;
        logic [3:0]  fl;
        logic        ab;
        logic [3:0]  cost;
    } item_t;
    item_t exp_q [$];
    string tag_q [$];

    logic [31:0] m_si = '0, m_di = '0, m_acc = '0;
    logic [3:0]  m_fl = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(logic [1:0] e);
        return (e == 2'd0) ? 1 : (e == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] msk(int n);
        return (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] mrd(logic [31:0] a, int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r |= 32'(mem[8'(a[7:0] + 8'(i))]) << (8 * i);
        return r;
    endfunction

    function automatic void mpoke(logic [31:0] a, int n, logic [31:0] v);
        for (int i = 0; i < n; i++) mem[8'(a[7:0] + 8'(i))] = v[8*i +: 8];
    endfunction

    function automatic logic [31:0] nxt_idx(logic [31:0] c, logic d, logic w, int n);
        logic [15:0] lo;
        if (w) return d ? c - 32'(n) : c + 32'(n);
        lo = d ? c[15:0] - 16'(n) : c[15:0] + 16'(n);
        return {c[31:16], lo};
    endfunction

    // reference flags {zf,sf,cf,of} of a - b at n bytes
    function automatic logic [3:0] rflags(logic [31:0] a, logic [31:0] b, int n);
        int w = 8 * n;
        logic [31:0] r;
        logic z, s, c, o;
        a = a & msk(n);
        b = b & msk(n);
        r = (a - b) & msk(n);
        z = (r == 0);
        s = r[w-1];
        c = (a < b);
        o = (a[w-1] != b[w-1]) && (r[w-1] != a[w-1]);
        return {z, s, c, o};
    endfunction

    // memory responder: one wait cycle, then ack or abort
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            mem_abort = 1'b0;
        end else if (mem_req && !mem_ack && !mem_abort) begin
            log_a.push_back(mem_addr);
            log_w.push_back(mem_we);
            if (fault_en && mem_addr == fault_addr) begin
                mem_abort = 1'b1;
            end else begin
                mem_ack = 1'b1;
                if (mem_we) mpoke(mem_addr, nbytes(mem_size), mem_wdata);
                else        mem_rdata = mrd(mem_addr, nbytes(mem_size));
            end
        end else begin
            mem_ack = 1'b0;
            mem_abort = 1'b0;
        end
    end

    // monitor: compare each completion against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R10 unexpected done: actual=1 expected=0");
            end else begin
                item_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "si", si, e.si);
                chk(t, "di", di, e.di);
                chk(t, "acc", acc, e.acc);
                chk(t, "flags", {28'h0, zf, sf, cf, of}, {28'h0, e.fl});
                chk(t, "aborted", {31'h0, aborted}, {31'h0, e.ab});
                chk({t, "/R9"}, "cost", {28'h0, cost}, {28'h0, e.cost});
            end
        end
    end

    task automatic set_regs(logic [31:0] s, logic [31:0] d, logic [31:0] a);
        @(negedge clk);
        ld_en = 1'b1; ld_si = s; ld_di = d; ld_acc = a;
        @(negedge clk);
        ld_en = 1'b0;
        m_si = s; m_di = d; m_acc = a;
        chk("R12", "load si", si, s);
        chk("R12", "load di", di, d);
        chk("R12", "load acc", acc, a);
    endtask

    // driver: predict, queue, launch, wait, then check memory and access order
    task automatic run_op(logic [2:0] o, logic [1:0] e, logic w, logic d, logic ng, string tag);
        int n = nbytes(e);
        logic [31:0] mk = msk(n);
        logic [31:0] ea_s = w ? m_si : {16'h0, m_si[15:0]};
        logic [31:0] ea_d = w ? m_di : {16'h0, m_di[15:0]};
        logic [31:0] src = mrd(ea_s, n);
        logic [31:0] dst = mrd(ea_d, n);
        logic [31:0] dst_exp = dst;
        bit uses_s = (o == 3'd0 || o == 3'd1 || o == 3'd3);
        bit uses_d = (o == 3'd0 || o == 3'd1 || o == 3'd2 || o == 3'd4);
        item_t it;
        int want_n;
        it.si = m_si; it.di = m_di; it.acc = m_acc; it.fl = m_fl;
        it.ab = fault_en && ((uses_s && ea_s == fault_addr) || (uses_d && ea_d == fault_addr));
        case (o)
            3'd0: it.cost = 4'd7;
            3'd1: it.cost = ng ? 4'd8 : 4'd10;
            3'd2: it.cost = 4'd7;
            3'd3: it.cost = 4'd5;
            3'd4: it.cost = 4'd4;
            default: it.cost = 4'd0;
        endcase
        if (!it.ab) begin
            case (o)
                3'd0: begin
                    it.si = nxt_idx(m_si, d, w, n); it.di = nxt_idx(m_di, d, w, n);
                    dst_exp = src;
                end
                3'd1: begin
                    it.fl = rflags(src, dst, n);
                    it.si = nxt_idx(m_si, d, w, n); it.di = nxt_idx(m_di, d, w, n);
                end
                3'd2: begin
                    it.fl = rflags(m_acc, dst, n);
                    it.di = nxt_idx(m_di, d, w, n);
                end
                3'd3: begin
                    it.acc = (m_acc & ~mk) | src;
                    it.si = nxt_idx(m_si, d, w, n);
                end
                3'd4: begin
                    dst_exp = m_acc & mk;
                    it.di = nxt_idx(m_di, d, w, n);
                end
                default: ;
            endcase
        end
        exp_q.push_back(it);
        tag_q.push_back(tag);
        log_a.delete();
        log_w.delete();
        @(negedge clk);
        start = 1'b1; op = o; esize = e; addr32 = w; dir = d; newgen = ng;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(tag, "dst memory", mrd(ea_d, n), dst_exp);
        if (!it.ab) begin
            want_n = (o > 3'd4) ? 0 : (o == 3'd0 || o == 3'd1) ? 2 : 1;
            chk((o > 3'd4) ? "R11" : "R10", "access count", 32'(log_a.size()), 32'(want_n));
            if (want_n == 2 && log_a.size() == 2) begin
                chk(tag, "first addr", log_a[0], ea_s);
                chk(tag, "first we", {31'h0, log_w[0]}, 32'h0);
                chk(tag, "second addr", log_a[1], ea_d);
                chk(tag, "second we", {31'h0, log_w[1]}, (o == 3'd0) ? 32'h1 : 32'h0);
            end
        end
        m_si = it.si; m_di = it.di; m_acc = it.acc; m_fl = it.fl;
        @(negedge clk);
        chk("R10", "done width", {31'h0, done}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12", "si", si, 32'h0);
        chk("R12", "di", di, 32'h0);
        chk("R12", "acc", acc, 32'h0);
        chk("R12", "flags", {28'h0, zf, sf, cf, of}, 32'h0);
        chk("R12", "idle", {29'h0, busy, done, mem_req}, 32'h0);

        set_regs(32'h0000_0010, 32'h0000_0080, 32'h1122_3344);
        run_op(3'd0, 2'd0, 1'b1, 1'b0, 1'b0, "R3");   // byte copy up
        run_op(3'd0, 2'd2, 1'b1, 1'b1, 1'b0, "R1");   // dword copy down
        run_op(3'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R1");   // word copy up

        // R2: 16-bit wrap both ways, upper bits kept
        set_regs(32'hABCD_FFFF, 32'h1234_FFFE, 32'h5566_7788);
        run_op(3'd0, 2'd1, 1'b0, 1'b0, 1'b0, "R2");
        set_regs(32'h0000_0040, 32'h1234_0000, 32'h5566_7788);
        run_op(3'd4, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
        set_regs(32'h0000_0040, 32'h0000_0000, 32'h5566_7788);
        run_op(3'd4, 2'd1, 1'b1, 1'b1, 1'b0, "R2");   // full 32-bit wrap

        // R7: loads keep the upper lanes
        set_regs(32'h0000_0020, 32'h0000_0090, 32'hAABB_CCDD);
        run_op(3'd3, 2'd0, 1'b1, 1'b0, 1'b0, "R7");
        run_op(3'd3, 2'd1, 1'b1, 1'b1, 1'b0, "R7");
        run_op(3'd3, 2'd2, 1'b1, 1'b0, 1'b0, "R7");

        // R8: stores
        set_regs(32'h0000_0020, 32'h0000_00A0, 32'hCAFE_BEEF);
        run_op(3'd4, 2'd1, 1'b1, 1'b0, 1'b0, "R8");
        run_op(3'd4, 2'd2, 1'b1, 1'b0, 1'b0, "R8");

        // R5/R6: compare-strings, operand order and flags
        set_regs(32'h0000_0030, 32'h0000_0050, 32'h0000_0000);
        mpoke(32'h30, 1, 32'h5A); mpoke(32'h50, 1, 32'h5A);
        run_op(3'd1, 2'd0, 1'b1, 1'b0, 1'b1, "R5");   // equal, newer cost
        mpoke(32'h31, 2, 32'h0001); mpoke(32'h51, 2, 32'h0002);
        run_op(3'd1, 2'd1, 1'b1, 1'b0, 1'b0, "R6");   // borrow and sign
        mpoke(32'h33, 4, 32'h8000_0000); mpoke(32'h53, 4, 32'h0000_0001);
        run_op(3'd1, 2'd2, 1'b1, 1'b0, 1'b0, "R6");   // signed overflow

        // R5/R6: scan uses accumulator minus element
        set_regs(32'h0000_0030, 32'h0000_0060, 32'h0000_0005);
        mpoke(32'h60, 1, 32'h10);
        run_op(3'd2, 2'd0, 1'b1, 1'b0, 1'b0, "R5");
        set_regs(32'h0000_0030, 32'h0000_0061, 32'h7FFF_FFFF);
        mpoke(32'h61, 4, 32'hFFFF_FFFF);
        run_op(3'd2, 2'd2, 1'b1, 1'b0, 1'b0, "R6");
        run_op(3'd4, 2'd0, 1'b1, 1'b0, 1'b0, "R6");   // store keeps flags

        // R4: aborts on copy write, compare first read, compare second read, load
        set_regs(32'h0000_0070, 32'h0000_00B0, 32'h0102_0304);
        fault_en = 1'b1;
        fault_addr = 32'h0000_00B0;
        run_op(3'd0, 2'd1, 1'b1, 1'b0, 1'b0, "R4");
        fault_addr = 32'h0000_0070;
        run_op(3'd1, 2'd0, 1'b1, 1'b0, 1'b1, "R4");
        fault_addr = 32'h0000_00B0;
        run_op(3'd1, 2'd2, 1'b1, 1'b0, 1'b0, "R4");
        fault_addr = 32'h0000_0070;
        run_op(3'd3, 2'd0, 1'b1, 1'b0, 1'b0, "R4");
        fault_en = 1'b0;

        // R11: reserved code
        run_op(3'd6, 2'd2, 1'b1, 1'b0, 1'b0, "R11");

        chk("R10", "scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule